// File: doc/BRIEF.md
# Bus-Idle Sleep Mode Controller

This block decides whether a battery monitor is measuring or asleep. It watches the already-synchronized levels of the two serial bus lines (clock and data) together with a sleep-enable configuration bit. When sleep is enabled and both lines have stayed low without a break for a long timeout, the block stops measurement activity. Any high level on either line brings it back at once.

Bus-low time is counted in prescaled ticks. A prescaler divides the system clock by `PRESCALE_DIV`, and a timer counts `TIMEOUT_TICKS` of those ticks. In silicon the timeout would be set near two seconds, and in simulation a short value is used. Sleep only gates the measurement-enable output. Register access over the bus goes on while asleep, and this block has no path to it.

After a wake-up, the measurement sequencer's next slot strobe is marked as a restart. Downstream logic can then discard or re-seed the first result.

Top module: `bus_sleep_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `meas_en` is 1, `asleep` is 0 and `slot_restart` is 0.
- R2: With `sleep_en` = 1 and both `scl_lvl` and `sda_lvl` at 0, `asleep` becomes 1 right after the N-th consecutive rising clock edge at which that condition holds, where N = `PRESCALE_DIV` * `TIMEOUT_TICKS`. It is still 0 after edge N-1.
- R3: A high level on either line during the count, even for one edge, restarts the count. Another full N edges of low bus are then needed.
- R4: With `sleep_en` = 0 the block never goes to sleep, however long the bus stays low. Dropping `sleep_en` for one edge during a count restarts that count.
- R5: While asleep, a 1 on `scl_lvl` or `sda_lvl` at a rising edge makes `meas_en` 1 and `asleep` 0 right after that edge.
- R6: `meas_en` is always the inverse of `asleep`.
- R7: The first `meas_slot` strobe after a wake-up drives `slot_restart` to 1 in the same cycle, without a register. Later strobes give 0. A strobe seen while asleep gives 0 and does not consume the restart mark.
- R8: Once asleep, clearing `sleep_en` does not wake the block. Only a high bus line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_lvl | input | 1 | Synchronized bus clock line level |
| sda_lvl | input | 1 | Synchronized bus data line level |
| sleep_en | input | 1 | Sleep-enable configuration bit (1 = sleep allowed) |
| meas_slot | input | 1 | Strobe marking the start of a measurement slot |
| meas_en | output | 1 | 1 while measurements may run (active mode) |
| asleep | output | 1 | 1 while in sleep mode |
| slot_restart | output | 1 | Marks the first measurement slot after a wake-up |

## Verification
Sleep entry is due right after the N-th low-bus edge. The bench drives the lines at a falling edge, waits exactly L rising edges and samples at the following falling edge, so a hold of N-1 edges and a hold of N edges can be told apart to the cycle. Wake-up is due one edge after a line goes high, and the bench samples after exactly one rising edge. `slot_restart` has no register, so it is sampled 1 ns after `meas_slot` is driven, within the same cycle, and again one cycle later to confirm the mark is gone.

// File: rtl/bus_sleep_pkg.sv
package bus_sleep_pkg;

    typedef enum logic {
        MODE_ACTIVE = 1'b0,
        MODE_SLEEP  = 1'b1
    } pwr_mode_t;

    // Both bus lines low: the only bus condition that may arm the timeout.
    function automatic logic bus_quiet(input logic scl, input logic sda);
        return !scl && !sda;
    endfunction

    // Either line high: the wake condition.
    function automatic logic bus_alive(input logic scl, input logic sda);
        return scl || sda;
    endfunction

    // Counter width able to hold values 0 .. limit-1 (at least one bit).
    function automatic int cnt_width(input int limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/bus_sleep_prescaler.sv
module bus_sleep_prescaler
    import bus_sleep_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = cnt_width(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Count restarts from zero whenever the run condition drops.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/bus_sleep_timer.sv
module bus_sleep_timer
    import bus_sleep_pkg::*;
#(
    parameter int TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int W = cnt_width(TICKS);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ticks_q <= '0;
        end else if (tick) begin
            ticks_q <= (ticks_q == LAST) ? '0 : ticks_q + 1'b1;
        end
    end

    assign expire = run && tick && (ticks_q == LAST);

endmodule

// File: rtl/bus_sleep_fsm.sv
module bus_sleep_fsm
    import bus_sleep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    input  logic      wake,
    input  logic      meas_slot,
    output pwr_mode_t mode,
    output logic      slot_restart
);
    pwr_mode_t mode_q, mode_d;
    logic      pend_q;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_ACTIVE: if (expire) mode_d = MODE_SLEEP;
            MODE_SLEEP:  if (wake)   mode_d = MODE_ACTIVE;
            default:     mode_d = MODE_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_ACTIVE;
            pend_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == MODE_SLEEP && wake) begin
                pend_q <= 1'b1;
            end else if (mode_q == MODE_ACTIVE && meas_slot) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign mode         = mode_q;
    assign slot_restart = (mode_q == MODE_ACTIVE) && meas_slot && pend_q;

endmodule

// File: rtl/bus_sleep_ctrl.sv
module bus_sleep_ctrl
    import bus_sleep_pkg::*;
#(
    parameter int PRESCALE_DIV  = 4,
    parameter int TIMEOUT_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_lvl,
    input  logic sda_lvl,
    input  logic sleep_en,
    input  logic meas_slot,
    output logic meas_en,
    output logic asleep,
    output logic slot_restart
);
    pwr_mode_t mode;
    logic      run;
    logic      tick;
    logic      expire;
    logic      wake;

    // Timeout only runs while active, enabled and with a quiet bus.
    assign run  = sleep_en && bus_quiet(scl_lvl, sda_lvl) && (mode == MODE_ACTIVE);
    assign wake = bus_alive(scl_lvl, sda_lvl);

    bus_sleep_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    bus_sleep_timer #(.TICKS(TIMEOUT_TICKS)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .expire (expire)
    );

    bus_sleep_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .expire       (expire),
        .wake         (wake),
        .meas_slot    (meas_slot),
        .mode         (mode),
        .slot_restart (slot_restart)
    );

    assign meas_en = (mode == MODE_ACTIVE);
    assign asleep  = (mode == MODE_SLEEP);

endmodule

// File: rtl/bus_sleep_ctrl_chk.sv
module bus_sleep_ctrl_chk #(
    parameter int PRESCALE_DIV  = 4,
    parameter int TIMEOUT_TICKS = 8
) (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic sda_lvl,
    input logic sleep_en,
    input logic meas_slot,
    input logic meas_en,
    input logic asleep,
    input logic slot_restart
);
    localparam int N = PRESCALE_DIV * TIMEOUT_TICKS;

    // Independent count of consecutive armed edges while awake.
    logic [31:0] run_q;
    always_ff @(posedge clk) begin
        if (rst || asleep || scl_lvl || sda_lvl || !sleep_en) begin
            run_q <= '0;
        end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 1;
        end
    end

    AST_RESET_ACTIVE: assert property (@(posedge clk)
        rst |=> (meas_en && !asleep && !slot_restart)); // R1

    AST_SLEEP_TIMED: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> (run_q == 32'(N))); // R2

    AST_SLEEP_NEEDS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!asleep && (scl_lvl || sda_lvl)) |=> !asleep); // R3

    AST_NO_SLEEP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!asleep && !sleep_en) |=> !asleep); // R4

    AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (asleep && (scl_lvl || sda_lvl)) |=> (meas_en && !asleep)); // R5

    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        meas_en != asleep); // R6

    AST_RESTART_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        slot_restart |-> (meas_en && meas_slot)); // R7

    AST_RESTART_ONCE: assert property (@(posedge clk) disable iff (rst)
        slot_restart |=> !slot_restart); // R7

    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (asleep && !scl_lvl && !sda_lvl) |=> asleep); // R8

endmodule

bind bus_sleep_ctrl bus_sleep_ctrl_chk #(
    .PRESCALE_DIV  (PRESCALE_DIV),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_lvl      (scl_lvl),
    .sda_lvl      (sda_lvl),
    .sleep_en     (sleep_en),
    .meas_slot    (meas_slot),
    .meas_en      (meas_en),
    .asleep       (asleep),
    .slot_restart (slot_restart)
);

// File: tb/bus_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module bus_sleep_ctrl_bench;
    localparam int DIV = 3;
    localparam int TO  = 4;
    localparam int N   = DIV * TO;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_lvl = 1'b1, sda_lvl = 1'b1, sleep_en = 1'b0, meas_slot = 1'b0;
    logic meas_en, asleep, slot_restart;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bus_sleep_ctrl #(.PRESCALE_DIV(DIV), .TIMEOUT_TICKS(TO)) u_bus_sleep_ctrl (
        .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .sleep_en(sleep_en), .meas_slot(meas_slot),
        .meas_en(meas_en), .asleep(asleep), .slot_restart(slot_restart)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Probe the restart mark with two slot strobes while awake.
    task automatic probe_slots(input logic exp_first);
        meas_slot = 1'b1;
        #1 check("R7 first slot after wake", slot_restart, exp_first);
        edges(1);
        #1 check("R7 later slot", slot_restart, 1'b0);
        meas_slot = 1'b0;
        edges(1);
    endtask

    // Hold bus low for L edges with sleep enabled, then release per pattern.
    task automatic low_run(input int L, input int pat);
        logic exp_sleep;
        exp_sleep = (L >= N);
        scl_lvl = 1'b0; sda_lvl = 1'b0; sleep_en = 1'b1;
        edges(L);
        check($sformatf("R2/R3 asleep after %0d low edges", L), asleep, exp_sleep);
        check("R6 meas_en inverse", meas_en, !exp_sleep);
        if (pat == 0)      scl_lvl = 1'b1;
        else if (pat == 1) sda_lvl = 1'b1;
        else begin scl_lvl = 1'b1; sda_lvl = 1'b1; end
        edges(1);
        check("R5 awake after release", meas_en, 1'b1);
        check("R5 asleep cleared", asleep, 1'b0);
        probe_slots(exp_sleep);
        scl_lvl = 1'b1; sda_lvl = 1'b1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        scl_lvl = 1'b0; sda_lvl = 1'b0; sleep_en = 1'b1;
        edges(N + 2);   // R1: reset dominates even with sleep conditions present
        check("R1 meas_en in reset", meas_en, 1'b1);
        check("R1 asleep in reset", asleep, 1'b0);
        meas_slot = 1'b1;
        #1 check("R1 no restart mark after reset", slot_restart, 1'b0);
        meas_slot = 1'b0;
        scl_lvl = 1'b1; sda_lvl = 1'b1;
        rst = 1'b0;
        edges(1);
        check("R1 meas_en after reset", meas_en, 1'b1);

        // R2 / R3 / R5 / R7 sweep over hold lengths and release patterns.
        for (int pat = 0; pat < 3; pat++)
            for (int L = 1; L <= N + 2; L++)
                low_run(L, pat);

        // R4: sleep disabled, long quiet bus.
        scl_lvl = 1'b0; sda_lvl = 1'b0; sleep_en = 1'b0;
        edges(3 * N);
        check("R4 no sleep when disabled", asleep, 1'b0);
        scl_lvl = 1'b1; sda_lvl = 1'b1; edges(1);

        // R4: enable dropped for one edge mid-count restarts the count.
        scl_lvl = 1'b0; sda_lvl = 1'b0; sleep_en = 1'b1;
        edges(N - 1);
        sleep_en = 1'b0; edges(1);
        sleep_en = 1'b1; edges(N - 1);
        check("R4 count restarted after enable drop", asleep, 1'b0);
        edges(1);
        check("R4 sleep after full count", asleep, 1'b1);

        // R7: a slot while asleep gives no mark and does not consume it.
        meas_slot = 1'b1;
        #1 check("R7 slot while asleep", slot_restart, 1'b0);
        edges(1);
        meas_slot = 1'b0;

        // R8: clearing enable while asleep does not wake.
        sleep_en = 1'b0;
        edges(5);
        check("R8 stays asleep with enable cleared", asleep, 1'b1);
        check("R6 meas_en low while asleep", meas_en, 1'b0);
        sda_lvl = 1'b1; edges(1);
        check("R5 wake on data line", meas_en, 1'b1);
        probe_slots(1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule